// File: doc/BRIEF.md
# DDR Burst Column Sequencer

This block turns a read or write command into the stream of column addresses that a double-data-rate memory core walks through during one burst. Two data beats move per clock, so every cycle the block presents an even-beat and an odd-beat column together. It raises a valid strobe for the pair, a flag on the final pair, and a direction bit. The burst length is chosen from four settings. The column order wraps around inside the block of columns that is aligned to that length. Columns above the burst-length field stay fixed at the starting value.

For reads, the block delays the pair-valid stream by the programmed CAS latency and so forms the window in which read data returns. For writes, it turns eight per-byte mask inputs into per-byte write enables for the even and odd beat of the current pair. A new command that arrives during a burst takes over at once. A burst-stop command with no new command ends the current burst. The burst length is captured when the command arrives. The latency setting is expected to stay constant while reads are in flight.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, every output is zero.
- R2: `cfg_bl` selects the burst length: 0 gives 2 beats, 1 gives 4, 2 gives 8 and 3 gives 16. A command sampled at a rising edge makes `col_valid` high from the next cycle on, for exactly length/2 cycles, with one pair per cycle.
- R3: Pair k carries beat 2k on `col_even` and beat 2k+1 on `col_odd`. Beat b has the column whose low log2(length) bits are (start + b) mod length. A length-16 burst that starts at 0x0A therefore runs A, B, ... F, 0, ... 9.
- R4: Column bits above the burst-length field equal the starting column for the whole burst.
- R5: `col_last` is high only on the final pair of a burst, and only together with `col_valid`.
- R6: `rd_valid` repeats the read pairs' valid (`col_valid` with `col_write` low) delayed by CAS latency minus one cycles. It therefore rises CL cycles after the READ command. `rd_last` repeats `col_last` of read pairs with the same delay. `cfg_cl` values 2, 3 and 4 are used as they are. A value below 2 acts as 2 and a value above 4 acts as 4.
- R7: A command sampled while a burst is in progress drops the rest of that burst. The first pair of the new burst appears in the next cycle.
- R8: `cmd_stop` sampled high with `cmd_valid` low makes `col_valid` low from the next cycle. The read window then closes the same delay later. When both are high, the command wins.
- R9: During a write pair, bit i of `wen_even`/`wen_odd` is the inverse of bit i of `wmask_even`/`wmask_odd`. Bit i covers byte lane i, data bits 8i+7 to 8i. A mask bit of 1 blocks that byte. Outside write pairs both enables are zero.
- R10: `col_write` shows the direction of the burst. Write bursts never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A read or write command is present this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | 8 | Starting column of the command |
| cmd_stop | input | 1 | Burst-stop command |
| cfg_bl | input | 2 | Burst length code (R2) |
| cfg_cl | input | 3 | CAS latency in clocks (R6) |
| wmask_even | input | 8 | Per-byte mask for the even beat, 1 blocks the byte |
| wmask_odd | input | 8 | Per-byte mask for the odd beat, 1 blocks the byte |
| col_even | output | 8 | Column of the even beat of the current pair |
| col_odd | output | 8 | Column of the odd beat of the current pair |
| col_valid | output | 1 | A column pair is presented |
| col_last | output | 1 | The presented pair is the last of its burst |
| col_write | output | 1 | The presented pair belongs to a write burst |
| rd_valid | output | 1 | Read data window, delayed by the CAS latency |
| rd_last | output | 1 | Final pair of the read window |
| wen_even | output | 8 | Per-byte write enables for the even beat |
| wen_odd | output | 8 | Per-byte write enables for the odd beat |

## Verification
Reads are run with every burst-length code and with starting columns at zero, in the middle and one short of the end of an aligned block. This separates a correct wrap from a plain increment, and shows whether the upper bits are held. The same read is repeated at latencies 2, 3 and 4, and at two out-of-range codes, so a wrong delay tap or missing clamping shows up as a shifted window. Reads are interrupted early and exactly on the last pair. Bursts are stopped, including a stop issued together with a command. Writes use a mask pattern that changes every cycle, which exposes lanes that are swapped, inverted wrongly or sampled in the wrong cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int COL_W      = 8;
    localparam int MAX_BL_LOG = 4;
    localparam int CNT_W      = MAX_BL_LOG - 1;
    localparam int LANES      = 8;
    localparam int CL_MIN     = 2;
    localparam int CL_MAX     = 4;
    localparam int TAP_W      = $clog2(CL_MAX);

    typedef logic [COL_W-1:0]      col_t;
    typedef logic [1:0]            bl_code_t;
    typedef logic [CNT_W-1:0]      cnt_t;
    typedef logic [MAX_BL_LOG-1:0] beat_t;
    typedef logic [TAP_W-1:0]      tap_t;

    typedef struct packed {
        logic valid;
        logic wr;
        logic last;
        col_t col_even;
        col_t col_odd;
    } pair_t;

    typedef struct packed {
        logic valid;
        logic last;
    } rd_tap_t;

    // Column of beat number 'beat' in a burst of 2<<code beats that starts at 'start'.
    function automatic col_t wrap_col(col_t start, bl_code_t code, beat_t beat);
        col_t field;
        field = (col_t'(2) << code) - col_t'(1);
        return (start & ~field) | ((start + col_t'(beat)) & field);
    endfunction

    // Index of the final pair of a burst of 2<<code beats.
    function automatic cnt_t last_pair(bl_code_t code);
        logic [CNT_W:0] pairs;
        pairs = (CNT_W+1)'(1) << code;
        return cnt_t'(pairs - (CNT_W+1)'(1));
    endfunction

    // Delay tap for a latency setting, clamped into the supported range.
    function automatic tap_t cl_tap(logic [2:0] cl);
        if (int'(cl) < CL_MIN) return tap_t'(CL_MIN - 1);
        if (int'(cl) > CL_MAX) return tap_t'(CL_MAX - 1);
        return tap_t'(int'(cl) - 1);
    endfunction

endpackage

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
    import bcs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_valid,
    input  logic     cmd_write,
    input  col_t     cmd_col,
    input  logic     cmd_stop,
    input  bl_code_t cfg_bl,
    output pair_t    pair_o
);

    logic     active_q;
    logic     wr_q;
    col_t     start_q;
    bl_code_t code_q;
    cnt_t     cnt_q;
    logic     at_end;

    assign at_end = (cnt_q == last_pair(code_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            wr_q     <= 1'b0;
            start_q  <= '0;
            code_q   <= '0;
            cnt_q    <= '0;
        end else if (cmd_valid) begin
            active_q <= 1'b1;
            wr_q     <= cmd_write;
            start_q  <= cmd_col;
            code_q   <= cfg_bl;
            cnt_q    <= '0;
        end else if (cmd_stop) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (at_end) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + cnt_t'(1);
            end
        end
    end

    always_comb begin
        pair_o          = '0;
        pair_o.valid    = active_q;
        pair_o.wr       = active_q & wr_q;
        pair_o.last     = active_q & at_end;
        if (active_q) begin
            pair_o.col_even = wrap_col(start_q, code_q, {cnt_q, 1'b0});
            pair_o.col_odd  = wrap_col(start_q, code_q, {cnt_q, 1'b1});
        end
    end

endmodule

// File: rtl/bcs_rd_window.sv
module bcs_rd_window
    import bcs_pkg::*;
#(
    parameter int DEPTH = CL_MAX
) (
    input  logic       clk,
    input  logic       rst,
    input  pair_t      pair_i,
    input  logic [2:0] cfg_cl,
    output logic       rd_valid,
    output logic       rd_last
);

    rd_tap_t tap_now;
    rd_tap_t tap_q   [1:DEPTH-1];
    rd_tap_t tap_all [0:DEPTH-1];
    tap_t    sel;

    assign tap_now.valid = pair_i.valid & ~pair_i.wr;
    assign tap_now.last  = pair_i.valid & ~pair_i.wr & pair_i.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 1; j < DEPTH; j++) tap_q[j] <= '0;
        end else begin
            tap_q[1] <= tap_now;
            for (int j = 2; j < DEPTH; j++) tap_q[j] <= tap_q[j-1];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_tap
            if (g == 0) begin : g_now
                assign tap_all[g] = tap_now;
            end else begin : g_dly
                assign tap_all[g] = tap_q[g];
            end
        end
    endgenerate

    assign sel      = cl_tap(cfg_cl);
    assign rd_valid = tap_all[sel].valid;
    assign rd_last  = tap_all[sel].last;

endmodule

// File: rtl/bcs_wmask.sv
module bcs_wmask
    import bcs_pkg::*;
#(
    parameter int NLANE = LANES
) (
    input  pair_t            pair_i,
    input  logic [NLANE-1:0] mask_even,
    input  logic [NLANE-1:0] mask_odd,
    output logic [NLANE-1:0] en_even,
    output logic [NLANE-1:0] en_odd
);

    logic wr_beat;
    assign wr_beat = pair_i.valid & pair_i.wr;

    generate
        for (genvar i = 0; i < NLANE; i++) begin : g_lane
            assign en_even[i] = wr_beat & ~mask_even[i];
            assign en_odd[i]  = wr_beat & ~mask_odd[i];
        end
    endgenerate

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    input  logic [1:0]       cfg_bl,
    input  logic [2:0]       cfg_cl,
    input  logic [LANES-1:0] wmask_even,
    input  logic [LANES-1:0] wmask_odd,
    output logic [COL_W-1:0] col_even,
    output logic [COL_W-1:0] col_odd,
    output logic             col_valid,
    output logic             col_last,
    output logic             col_write,
    output logic             rd_valid,
    output logic             rd_last,
    output logic [LANES-1:0] wen_even,
    output logic [LANES-1:0] wen_odd
);

    pair_t pair;

    bcs_addr_gen u_addr (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_col   (cmd_col),
        .cmd_stop  (cmd_stop),
        .cfg_bl    (cfg_bl),
        .pair_o    (pair)
    );

    bcs_rd_window #(.DEPTH(CL_MAX)) u_rdwin (
        .clk      (clk),
        .rst      (rst),
        .pair_i   (pair),
        .cfg_cl   (cfg_cl),
        .rd_valid (rd_valid),
        .rd_last  (rd_last)
    );

    bcs_wmask #(.NLANE(LANES)) u_wmask (
        .pair_i    (pair),
        .mask_even (wmask_even),
        .mask_odd  (wmask_odd),
        .en_even   (wen_even),
        .en_odd    (wen_odd)
    );

    assign col_even  = pair.col_even;
    assign col_odd   = pair.col_odd;
    assign col_valid = pair.valid;
    assign col_last  = pair.last;
    assign col_write = pair.wr;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_stop,
    input logic [2:0] cfg_cl,
    input logic [7:0] col_even,
    input logic [7:0] col_odd,
    input logic       col_valid,
    input logic       col_last,
    input logic       col_write,
    input logic       rd_valid,
    input logic [7:0] wen_even,
    input logic [7:0] wen_odd
);

    p_last_inside_r5: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    p_cmd_takes_over_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> col_valid);

    p_stop_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_stop && !cmd_valid) |=> !col_valid);

    p_pair_beats_r3: assert property (@(posedge clk) disable iff (rst)
        col_valid |-> (col_even[0] != col_odd[0]));

    p_upper_held_r4: assert property (@(posedge clk) disable iff (rst)
        (col_valid && $past(col_valid) && !$past(cmd_valid))
            |-> (col_even[7:4] == $past(col_even[7:4])));

    p_wen_write_only_r9: assert property (@(posedge clk) disable iff (rst)
        ((|wen_even) || (|wen_odd)) |-> (col_valid && col_write));

    p_rd_cl2_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_cl == 3'd2 && $past(cfg_cl) == 3'd2)
            |-> (rd_valid == $past(col_valid && !col_write)));

    p_rd_cl3_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_cl == 3'd3 && $past(cfg_cl) == 3'd3 && $past(cfg_cl, 2) == 3'd3)
            |-> (rd_valid == $past(col_valid && !col_write, 2)));

endmodule

bind burst_col_seq bcs_checker u_bcs_checker (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_stop  (cmd_stop),
    .cfg_cl    (cfg_cl),
    .col_even  (col_even),
    .col_odd   (col_odd),
    .col_valid (col_valid),
    .col_last  (col_last),
    .col_write (col_write),
    .rd_valid  (rd_valid),
    .wen_even  (wen_even),
    .wen_odd   (wen_odd)
);

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_col = '0;
    logic       cmd_stop = 1'b0;
    logic [1:0] cfg_bl = '0;
    logic [2:0] cfg_cl = 3'd2;
    logic [7:0] wmask_even = '0;
    logic [7:0] wmask_odd = '0;
    logic [7:0] col_even, col_odd, wen_even, wen_odd;
    logic       col_valid, col_last, col_write, rd_valid, rd_last;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int mask_seed = 17;

    burst_col_seq u_burst_col_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .cmd_stop(cmd_stop), .cfg_bl(cfg_bl), .cfg_cl(cfg_cl),
        .wmask_even(wmask_even), .wmask_odd(wmask_odd),
        .col_even(col_even), .col_odd(col_odd), .col_valid(col_valid),
        .col_last(col_last), .col_write(col_write), .rd_valid(rd_valid),
        .rd_last(rd_last), .wen_even(wen_even), .wen_odd(wen_odd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: a queue of pending pairs, packed as
    // bit 18 valid, 17 write, 16 last, 15:8 odd column, 7:0 even column.
    int pend[$];
    int rv_hist[4];
    int rl_hist[4];

    always @(posedge clk) begin
        if (rst) begin
            pend.delete();
            for (int j = 0; j < 4; j++) begin rv_hist[j] = 0; rl_hist[j] = 0; end
        end else begin
            if (cmd_valid) begin
                int len, base, e, o, fr;
                pend.delete();
                len  = 2 << cfg_bl;
                base = int'(cmd_col) & ~(len - 1) & 255;
                for (int k = 0; k < len / 2; k++) begin
                    e  = base | ((int'(cmd_col) + 2 * k) & (len - 1));
                    o  = base | ((int'(cmd_col) + 2 * k + 1) & (len - 1));
                    fr = (1 << 18) | (int'(cmd_write) << 17)
                       | (((k == len / 2 - 1) ? 1 : 0) << 16) | (o << 8) | e;
                    pend.push_back(fr);
                end
            end else if (cmd_stop) begin
                pend.delete();
            end else if (pend.size() > 0) begin
                void'(pend.pop_front());
            end
            for (int j = 3; j > 0; j--) begin
                rv_hist[j] = rv_hist[j-1];
                rl_hist[j] = rl_hist[j-1];
            end
            if (pend.size() > 0 && pend[0][17] == 1'b0) begin
                rv_hist[0] = 1;
                rl_hist[0] = pend[0][16];
            end else begin
                rv_hist[0] = 0;
                rl_hist[0] = 0;
            end
        end
    end

    task automatic check(string tag, int act, int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp_v, $time);
        end
    endtask

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            int fr, cl, ee, eo;
            fr = (pend.size() > 0) ? pend[0] : 0;
            check("R2 col_valid", int'(col_valid), (fr >> 18) & 1);
            check("R10 col_write", int'(col_write), (fr >> 17) & 1);
            check("R5 col_last", int'(col_last), (fr >> 16) & 1);
            if (fr[18]) begin
                check("R3 col_even", int'(col_even), fr & 255);
                check("R4 col_odd", int'(col_odd), (fr >> 8) & 255);
            end
            cl = (cfg_cl < 3'd2) ? 2 : (cfg_cl > 3'd4) ? 4 : int'(cfg_cl);
            check("R6 rd_valid", int'(rd_valid), rv_hist[cl-1]);
            check("R6 rd_last", int'(rd_last), rl_hist[cl-1]);
            ee = (fr[18] && fr[17]) ? (~int'(wmask_even) & 255) : 0;
            eo = (fr[18] && fr[17]) ? (~int'(wmask_odd) & 255) : 0;
            check("R9 wen_even", int'(wen_even), ee);
            check("R9 wen_odd", int'(wen_odd), eo);
        end
    end

    // Inputs change 1 ns after each rising edge; masks move every cycle.
    task automatic tick();
        @(posedge clk);
        #1;
        mask_seed  = (mask_seed * 37 + 11) % 251;
        wmask_even = 8'(mask_seed);
        wmask_odd  = 8'(mask_seed ^ 8'h5A);
        cmd_valid  = 1'b0;
        cmd_stop   = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic issue(bit wr, logic [7:0] col, logic [1:0] bl);
        tick();
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_col   = col;
        cfg_bl    = bl;
    endtask

    task automatic stop_now();
        tick();
        cmd_stop = 1'b1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        // R1: outputs are zero under reset
        check("R1 reset col_valid", int'(col_valid), 0);
        check("R1 reset rd_valid", int'(rd_valid), 0);
        check("R1 reset wen", int'({wen_even, wen_odd}), 0);
        check("R1 reset cols", int'({col_even, col_odd}), 0);
        tick();
        rst = 1'b0;

        // R2 R3 R4: each length, wrap order, held upper bits (CL 2)
        cfg_cl = 3'd2;
        issue(0, 8'h0A, 2'd3); idle(12);
        issue(0, 8'h37, 2'd2); idle(8);
        issue(0, 8'h05, 2'd0); idle(5);
        issue(0, 8'hFE, 2'd1); idle(6);
        issue(0, 8'h9F, 2'd3); idle(12);

        // R6: latencies 3 and 4, plus clamped codes
        cfg_cl = 3'd3; idle(2);
        issue(0, 8'h21, 2'd2); idle(9);
        cfg_cl = 3'd4; idle(2);
        issue(0, 8'h42, 2'd2); idle(10);
        cfg_cl = 3'd1; idle(4);
        issue(0, 8'h13, 2'd1); idle(6);
        cfg_cl = 3'd7; idle(4);
        issue(0, 8'h6C, 2'd1); idle(8);

        // R7: read interrupted by read, early and on the last pair
        cfg_cl = 3'd3; idle(4);
        issue(0, 8'h80, 2'd3); idle(2);
        issue(0, 8'hC6, 2'd2); idle(2);
        issue(0, 8'h11, 2'd1);
        issue(0, 8'h2D, 2'd0); idle(8);

        // R8: burst stop, and stop together with a command
        issue(0, 8'h50, 2'd3); idle(2);
        stop_now(); idle(6);
        issue(0, 8'h70, 2'd2); idle(1);
        tick(); cmd_stop = 1'b1; cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 8'h7B; cfg_bl = 2'd1;
        idle(8);

        // R9 R10: writes with changing masks, write cut by read, write stop
        issue(1, 8'h43, 2'd2); idle(6);
        issue(1, 8'hE9, 2'd3); idle(3);
        issue(0, 8'h08, 2'd2); idle(8);
        issue(1, 8'h34, 2'd3); idle(2);
        stop_now(); idle(3);
        issue(1, 8'hFF, 2'd0); idle(5);

        idle(4);
        done = 1;
        summary();
    end

endmodule